// File: doc/BRIEF.md
# Task Context Switch Sequencer

This block carries out the memory traffic of a hardware task switch. When a switch is requested, it first asks an external page-presence oracle about the first and last word of both the outgoing and the incoming task record. If all four answers are "present", it writes the outgoing task's changing state into the outgoing record. For a nested switch it then stores a back-pointer to the outgoing record in the incoming one. Finally it reads the incoming task's full state. Both record bases are word addresses.

Each record has 26 words. The word offsets are fixed: back-pointer 0; three privileged stack pointer/selector pairs 1..6, in the order pointer then selector for levels 0, 1, 2; page-directory base 7; instruction pointer 8; flags 9; general registers 10..17; segment selectors 18..23; local-table selector 24; control word 25. In the control word, bit 0 is the per-task debug-trap bit and bits 31:16 are the I/O map base. Selector fields carry their value in bits 15:0 and zeros above.

Loaded words collect in a shadow bank. The bank reaches the register file as one pulse at the end, so an aborted switch leaves the register file untouched. The register-file values to be saved must be held steady for the whole switch.

Top module: `ctx_switch_seq`

## Requirements
- R1: After reset, `req_ready` is 1 and `mem_valid`, `done`, `pf_fault`, `ld_valid` and `dbg_trap` are 0.
- R2: The save phase writes instruction pointer, flags, the eight general registers and the six zero-extended segment selectors to old-record offsets 8..23. It never writes offsets 0..7, 24 or 25 of the old record, and it writes no word of the new record other than offset 0.
- R3: When `req_nest` is 1, new-record offset 0 receives the old record base, zero-extended. When `req_nest` is 0, that word is left unchanged.
- R4: On completion, `ld_valid` and `done` are high together for one cycle. At that point every `ld_*` output holds the corresponding new-record word: stacks from 1..6, ip 8, flags 9, registers 10..17, selectors 18..23, local-table selector 24, control word 25.
- R5: With `req_paging` 1, offset 7 is read, driven on `ld_pdb`, and `ld_pdb_valid` is 1. With `req_paging` 0, offset 7 is never read and `ld_pdb_valid` is 0.
- R6: `dbg_trap` pulses together with `done` exactly when bit 0 of new-record offset 25 is 1.
- R7: The four probes are issued in the order old start, old end (base+25), new start, new end. The first probe that reports absent pulses `pf_fault`, puts the probed address on `pf_addr`, and returns the block to idle. In that case there is no memory access at all and no `ld_valid`. A record whose end lies in an absent higher page counts as a fault.
- R8: At most one memory access is made per cycle. `mem_valid`, `mem_we`, `mem_addr` and `mem_wdata` hold steady until `mem_ready`, and stall cycles delay completion without changing results.
- R9: With `mem_ready` held at 1, `done` rises 4 + 16 + nest + 24 + paging clock edges after the accepting edge. A probe failing at position p (1..4) raises `pf_fault` p edges after acceptance.
- R10: While a switch is in progress `req_ready` is 0, and requests presented then are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Switch request |
| req_ready | output | 1 | Idle, request accepted this cycle |
| req_old_base | input | AW | Outgoing record base |
| req_new_base | input | AW | Incoming record base |
| req_nest | input | 1 | Store back-pointer in new record |
| req_paging | input | 1 | Paging enabled, load page-directory base |
| mem_valid | output | 1 | Memory access request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Access completes this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ready |
| pq_addr | output | AW | Address whose page is probed |
| pq_present | input | 1 | Probed page is present |
| rf_gpr | input | 8*DW | General registers to save, register i at bits i*DW |
| rf_seg | input | 6*SELW | Segment selectors to save |
| rf_flags | input | DW | Flags to save |
| rf_ip | input | DW | Instruction pointer to save |
| ld_valid | output | 1 | Commit pulse for loaded state |
| ld_gpr | output | 8*DW | Loaded general registers |
| ld_seg | output | 6*DW | Loaded selector words |
| ld_flags | output | DW | Loaded flags |
| ld_ip | output | DW | Loaded instruction pointer |
| ld_ldt | output | DW | Loaded local-table selector word |
| ld_stk | output | 6*DW | Loaded stack pointer/selector words |
| ld_pdb | output | DW | Loaded page-directory base |
| ld_pdb_valid | output | 1 | ld_pdb was loaded by the last switch |
| ld_ctrl | output | DW | Loaded control word |
| done | output | 1 | Switch completed |
| pf_fault | output | 1 | Switch aborted on absent page |
| pf_addr | output | AW | Address of the failing probe |
| dbg_trap | output | 1 | Incoming task requests debug trap |

## Verification
Every result has a fixed distance in clock edges from the edge that accepts the request. With memory always ready, completion comes after 44 to 46 edges, depending on the nest and paging bits. A fault comes after 1 to 4 edges, depending on which probe fails. The bench counts rising edges from the accepting edge and samples on the following falling edge. It compares that count with the formula, and it checks the `ld_*`, `dbg_trap` and memory contents in that same sampling slot. The stalled run is checked for correct results and for a longer latency only, because its exact count depends on the ready pattern.

// File: rtl/ctx_pkg.sv
`timescale 1ns/1ps
package ctx_pkg;
    localparam int OFFW      = 5;
    localparam int REC_WORDS = 26;
    localparam int NGPR      = 8;
    localparam int NSEG      = 6;
    localparam int NSTK      = 6;

    localparam logic [OFFW-1:0] OFF_LINK  = 5'd0;
    localparam logic [OFFW-1:0] OFF_STK   = 5'd1;
    localparam logic [OFFW-1:0] OFF_PDB   = 5'd7;
    localparam logic [OFFW-1:0] OFF_IP    = 5'd8;
    localparam logic [OFFW-1:0] OFF_FLAGS = 5'd9;
    localparam logic [OFFW-1:0] OFF_GPR   = 5'd10;
    localparam logic [OFFW-1:0] OFF_SEG   = 5'd18;
    localparam logic [OFFW-1:0] OFF_LDT   = 5'd24;
    localparam logic [OFFW-1:0] OFF_CTRL  = 5'd25;
    localparam logic [OFFW-1:0] OFF_SAVE_LAST = OFFW'(int'(OFF_SEG) + NSEG - 1);

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PROBE = 3'd1,
        PH_SAVE  = 3'd2,
        PH_LINK  = 3'd3,
        PH_LOAD  = 3'd4
    } phase_e;

    // Next offset to read in the load phase; the directory base slot is
    // passed over when paging is off.
    function automatic logic [OFFW-1:0] load_next(input logic [OFFW-1:0] cur,
                                                  input logic paging);
        logic [OFFW-1:0] n;
        n = cur + OFFW'(1);
        if (n == OFF_PDB && !paging)
            n = cur + OFFW'(2);
        return n;
    endfunction
endpackage

// File: rtl/ctx_save_mux.sv
`timescale 1ns/1ps
module ctx_save_mux
    import ctx_pkg::*;
#(
    parameter int DW   = 32,
    parameter int SELW = 16
) (
    input  logic [OFFW-1:0]      off,
    input  logic [NGPR*DW-1:0]   gpr,
    input  logic [NSEG*SELW-1:0] seg,
    input  logic [DW-1:0]        flags,
    input  logic [DW-1:0]        ip,
    output logic [DW-1:0]        word
);
    localparam int SLOTS = 2 ** OFFW;

    logic [DW-1:0] cand [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g == int'(OFF_IP)) begin : g_ip
            assign cand[g] = ip;
        end else if (g == int'(OFF_FLAGS)) begin : g_fl
            assign cand[g] = flags;
        end else if (g >= int'(OFF_GPR) && g < int'(OFF_GPR) + NGPR) begin : g_gpr
            assign cand[g] = gpr[(g - int'(OFF_GPR))*DW +: DW];
        end else if (g >= int'(OFF_SEG) && g < int'(OFF_SEG) + NSEG) begin : g_seg
            assign cand[g] = {{(DW-SELW){1'b0}}, seg[(g - int'(OFF_SEG))*SELW +: SELW]};
        end else begin : g_none
            assign cand[g] = '0;
        end
    end

    assign word = cand[off];
endmodule

// File: rtl/ctx_page_probe.sv
`timescale 1ns/1ps
module ctx_page_probe
    import ctx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic [AW-1:0] old_base,
    input  logic [AW-1:0] new_base,
    input  logic [1:0]    idx,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] LAST = AW'(REC_WORDS - 1);

    always_comb begin
        unique case (idx)
            2'd0:    addr = old_base;
            2'd1:    addr = old_base + LAST;
            2'd2:    addr = new_base;
            default: addr = new_base + LAST;
        endcase
    end
endmodule

// File: rtl/ctx_shadow.sv
`timescale 1ns/1ps
module ctx_shadow
    import ctx_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cap_en,
    input  logic [OFFW-1:0]               off,
    input  logic [DW-1:0]                 din,
    output logic [(REC_WORDS-1)*DW-1:0]   words
);
    // Slot g-1 holds record offset g; offset 0 is never loaded.
    for (genvar g = 1; g < REC_WORDS; g++) begin : g_word
        logic [DW-1:0] w_q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                w_q <= '0;
            else if (cap_en && off == OFFW'(g))
                w_q <= din;
        end
        assign words[(g-1)*DW +: DW] = w_q;
    end
endmodule

// File: rtl/ctx_switch_seq.sv
`timescale 1ns/1ps
module ctx_switch_seq
    import ctx_pkg::*;
#(
    parameter int AW   = 16,
    parameter int DW   = 32,
    parameter int SELW = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [AW-1:0]         req_old_base,
    input  logic [AW-1:0]         req_new_base,
    input  logic                  req_nest,
    input  logic                  req_paging,
    output logic                  mem_valid,
    output logic                  mem_we,
    output logic [AW-1:0]         mem_addr,
    output logic [DW-1:0]         mem_wdata,
    input  logic                  mem_ready,
    input  logic [DW-1:0]         mem_rdata,
    output logic [AW-1:0]         pq_addr,
    input  logic                  pq_present,
    input  logic [NGPR*DW-1:0]    rf_gpr,
    input  logic [NSEG*SELW-1:0]  rf_seg,
    input  logic [DW-1:0]         rf_flags,
    input  logic [DW-1:0]         rf_ip,
    output logic                  ld_valid,
    output logic [NGPR*DW-1:0]    ld_gpr,
    output logic [NSEG*DW-1:0]    ld_seg,
    output logic [DW-1:0]         ld_flags,
    output logic [DW-1:0]         ld_ip,
    output logic [DW-1:0]         ld_ldt,
    output logic [NSTK*DW-1:0]    ld_stk,
    output logic [DW-1:0]         ld_pdb,
    output logic                  ld_pdb_valid,
    output logic [DW-1:0]         ld_ctrl,
    output logic                  done,
    output logic                  pf_fault,
    output logic [AW-1:0]         pf_addr,
    output logic                  dbg_trap
);
    typedef struct packed {
        phase_e          phase;
        logic [1:0]      idx;
        logic [OFFW-1:0] off;
        logic [AW-1:0]   old_base;
        logic [AW-1:0]   new_base;
        logic            nest;
        logic            paging;
        logic            done;
        logic            pf;
        logic [AW-1:0]   pf_addr;
        logic            ld_valid;
        logic            dbg;
        logic            pdb_valid;
    } st_t;

    st_t q, d;
    logic [DW-1:0] save_word;
    logic          cap_en;
    logic [(REC_WORDS-1)*DW-1:0] sh;

    ctx_save_mux #(.DW(DW), .SELW(SELW)) u_mux (
        .off(q.off), .gpr(rf_gpr), .seg(rf_seg), .flags(rf_flags), .ip(rf_ip),
        .word(save_word)
    );

    ctx_page_probe #(.AW(AW)) u_probe (
        .old_base(q.old_base), .new_base(q.new_base), .idx(q.idx), .addr(pq_addr)
    );

    ctx_shadow #(.DW(DW)) u_shadow (
        .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .off(q.off), .din(mem_rdata),
        .words(sh)
    );

    always_comb begin
        d          = q;
        d.done     = 1'b0;
        d.pf       = 1'b0;
        d.ld_valid = 1'b0;
        d.dbg      = 1'b0;
        mem_valid  = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = q.new_base + AW'(q.off);
        mem_wdata  = save_word;
        cap_en     = 1'b0;
        unique case (q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    d.phase    = PH_PROBE;
                    d.idx      = 2'd0;
                    d.old_base = req_old_base;
                    d.new_base = req_new_base;
                    d.nest     = req_nest;
                    d.paging   = req_paging;
                end
            end
            PH_PROBE: begin
                if (!pq_present) begin
                    d.pf      = 1'b1;
                    d.pf_addr = pq_addr;
                    d.phase   = PH_IDLE;
                end else if (q.idx == 2'd3) begin
                    d.phase = PH_SAVE;
                    d.off   = OFF_IP;
                end else begin
                    d.idx = q.idx + 2'd1;
                end
            end
            PH_SAVE: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.old_base + AW'(q.off);
                if (mem_ready) begin
                    if (q.off == OFF_SAVE_LAST) begin
                        d.phase = q.nest ? PH_LINK : PH_LOAD;
                        d.off   = OFF_STK;
                    end else begin
                        d.off = q.off + OFFW'(1);
                    end
                end
            end
            PH_LINK: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.new_base + AW'(OFF_LINK);
                mem_wdata = DW'(q.old_base);
                if (mem_ready)
                    d.phase = PH_LOAD;
            end
            PH_LOAD: begin
                mem_valid = 1'b1;
                cap_en    = mem_ready;
                if (mem_ready) begin
                    if (q.off == OFF_CTRL) begin
                        d.phase     = PH_IDLE;
                        d.done      = 1'b1;
                        d.ld_valid  = 1'b1;
                        d.dbg       = mem_rdata[0];
                        d.pdb_valid = q.paging;
                    end else begin
                        d.off = load_next(q.off, q.paging);
                    end
                end
            end
            default: d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else
            q <= d;
    end

    assign req_ready    = (q.phase == PH_IDLE);
    assign done         = q.done;
    assign pf_fault     = q.pf;
    assign pf_addr      = q.pf_addr;
    assign ld_valid     = q.ld_valid;
    assign dbg_trap     = q.dbg;
    assign ld_pdb_valid = q.pdb_valid;

    assign ld_ip    = sh[(int'(OFF_IP)-1)*DW +: DW];
    assign ld_flags = sh[(int'(OFF_FLAGS)-1)*DW +: DW];
    assign ld_pdb   = sh[(int'(OFF_PDB)-1)*DW +: DW];
    assign ld_ldt   = sh[(int'(OFF_LDT)-1)*DW +: DW];
    assign ld_ctrl  = sh[(int'(OFF_CTRL)-1)*DW +: DW];
    for (genvar i = 0; i < NGPR; i++) begin : g_lgpr
        assign ld_gpr[i*DW +: DW] = sh[(int'(OFF_GPR)+i-1)*DW +: DW];
    end
    for (genvar i = 0; i < NSEG; i++) begin : g_lseg
        assign ld_seg[i*DW +: DW] = sh[(int'(OFF_SEG)+i-1)*DW +: DW];
    end
    for (genvar i = 0; i < NSTK; i++) begin : g_lstk
        assign ld_stk[i*DW +: DW] = sh[(int'(OFF_STK)+i-1)*DW +: DW];
    end

    // R2/R3: writes land only on the dynamic slots or the nested back-pointer
    p_static_untouched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_we) |->
            (((mem_addr - q.old_base) >= AW'(OFF_IP)) &&
             ((mem_addr - q.old_base) <= AW'(OFF_SAVE_LAST))) ||
            (q.nest && mem_addr == q.new_base));

    p_link_nested_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.phase == PH_LINK) |-> q.nest);

    p_commit_after_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid |-> ($past(mem_valid && !mem_we && mem_ready) && done));

    p_pdb_skipped_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we && !q.paging) |-> (mem_addr != q.new_base + AW'(OFF_PDB)));

    p_trap_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_trap |-> done);

    p_fault_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pf_fault |-> (!ld_valid && !done && !mem_valid));

    p_hold_until_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_valid);
endmodule

// File: tb/sim_ctx_switch_seq.sv
`timescale 1ns/1ps
module sim_ctx_switch_seq;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int SELW = 16;
    localparam logic [15:0] PRESENT = 16'hAFFF; // pages 12 and 14 absent

    // {old_base, new_base, nest, paging, trap}
    localparam logic [34:0] VEC [4] = '{
        {16'h0040, 16'h0080, 1'b0, 1'b0, 1'b0},
        {16'h0100, 16'h0140, 1'b1, 1'b1, 1'b0},
        {16'h0180, 16'h01C0, 1'b1, 1'b0, 1'b1},
        {16'h0030, 16'h0200, 1'b0, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_nest = 1'b0, req_paging = 1'b0;
    logic [AW-1:0] req_old_base = '0, req_new_base = '0;
    logic req_ready, mem_valid, mem_we, mem_ready, pq_present;
    logic [AW-1:0] mem_addr, pq_addr, pf_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [8*DW-1:0] rf_gpr = '0;
    logic [6*SELW-1:0] rf_seg = '0;
    logic [DW-1:0] rf_flags = '0, rf_ip = '0;
    logic ld_valid, ld_pdb_valid, done, pf_fault, dbg_trap;
    logic [8*DW-1:0] ld_gpr;
    logic [6*DW-1:0] ld_seg, ld_stk;
    logic [DW-1:0] ld_flags, ld_ip, ld_ldt, ld_pdb, ld_ctrl;

    logic [31:0] mem [0:1023];
    logic stall = 1'b0;
    logic [7:0] tick = '0;
    int tests = 0, fails = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) tick <= tick + 8'd1;
    always @(posedge clk)
        if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    assign mem_ready  = stall ? tick[0] : 1'b1;
    assign mem_rdata  = mem[mem_addr[9:0]];
    assign pq_present = (pq_addr < 16'd1024) && PRESENT[pq_addr[9:6]];

    ctx_switch_seq #(.AW(AW), .DW(DW), .SELW(SELW)) u0 (
        .clk, .rst_n, .req_valid, .req_ready, .req_old_base, .req_new_base,
        .req_nest, .req_paging, .mem_valid, .mem_we, .mem_addr, .mem_wdata,
        .mem_ready, .mem_rdata, .pq_addr, .pq_present, .rf_gpr, .rf_seg,
        .rf_flags, .rf_ip, .ld_valid, .ld_gpr, .ld_seg, .ld_flags, .ld_ip,
        .ld_ldt, .ld_stk, .ld_pdb, .ld_pdb_valid, .ld_ctrl, .done, .pf_fault,
        .pf_addr, .dbg_trap
    );

    function automatic logic [31:0] rec_w(input logic [15:0] b, input int off);
        return 32'hA5000000 | (32'(b) << 8) | 32'(off);
    endfunction
    function automatic logic [31:0] sent_w(input logic [15:0] b, input int off);
        return 32'h5E000000 | (32'(b) << 8) | 32'(off);
    endfunction
    function automatic logic [31:0] ctrl_w(input logic [15:0] b, input bit trap);
        return {b ^ 16'h4000, 15'h0, trap};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_old(input logic [15:0] b);
        for (int k = 0; k < 26; k++) mem[b + 16'(k)] = sent_w(b, k);
    endtask
    task automatic fill_new(input logic [15:0] b, input bit trap);
        for (int k = 0; k < 25; k++) mem[b + 16'(k)] = rec_w(b, k);
        mem[b + 16'd25] = ctrl_w(b, trap);
    endtask
    task automatic set_rf(input int v);
        for (int i = 0; i < 8; i++) rf_gpr[i*32 +: 32] = 32'h11000000 + 32'(v*16 + i);
        for (int i = 0; i < 6; i++) rf_seg[i*16 +: 16] = 16'h0800 + 16'(v*16 + i);
        rf_flags = 32'h00000202 + 32'(v);
        rf_ip    = 32'h00C00000 + 32'(v);
    endtask
    function automatic logic [31:0] save_exp(input int off);
        if (off == 8) return rf_ip;
        if (off == 9) return rf_flags;
        if (off < 18) return rf_gpr[(off-10)*32 +: 32];
        return {16'h0, rf_seg[(off-18)*16 +: 16]};
    endfunction

    // Runs one switch; lat is the edge count from the accepting edge.
    task automatic run_sw(input logic [15:0] ob, input logic [15:0] nb, input bit ns,
                          input bit pg, input bit intrude, output int lat,
                          output bit got_done, output bit got_pf,
                          output bit saw_ld, output bit saw_dbg);
        lat = 0; got_done = 0; got_pf = 0; saw_ld = 0; saw_dbg = 0;
        @(negedge clk);
        req_old_base = ob; req_new_base = nb; req_nest = ns; req_paging = pg;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 1; k <= 400; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (intrude && k == 5) begin
                req_old_base = 16'h0280; req_new_base = 16'h02A0; req_valid = 1'b1;
                chk("R10 req_ready low while busy", 32'(req_ready), 32'd0);
            end
            if (intrude && k == 8) req_valid = 1'b0;
            if (done || pf_fault) begin
                lat = k; got_done = done; got_pf = pf_fault;
                saw_ld = ld_valid; saw_dbg = dbg_trap;
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int lat;
        bit gd, gp, sl, sd;
        for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 req_ready in reset", 32'(req_ready), 32'd1);
        chk("R1 mem_valid in reset", 32'(mem_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 32'(done), 32'd0);
        chk("R1 pf_fault after reset", 32'(pf_fault), 32'd0);
        chk("R1 ld_valid after reset", 32'(ld_valid), 32'd0);
        chk("R1 dbg_trap after reset", 32'(dbg_trap), 32'd0);

        for (int v = 0; v < 4; v++) begin
            logic [15:0] ob, nb;
            bit ns, pg, tr;
            {ob, nb, ns, pg, tr} = VEC[v];
            fill_old(ob);
            fill_new(nb, tr);
            set_rf(v);
            run_sw(ob, nb, ns, pg, 1'b0, lat, gd, gp, sl, sd);
            chk("R9 latency", 32'(lat), 32'(4 + 16 + int'(ns) + 24 + int'(pg)));
            chk("R4 done", 32'(gd), 32'd1);
            chk("R4 ld_valid with done", 32'(sl), 32'd1);
            chk("R6 dbg_trap", 32'(sd), 32'(tr));
            for (int o = 8; o < 24; o++) chk("R2 saved word", mem[ob + 16'(o)], save_exp(o));
            for (int o = 0; o < 26; o++)
                if (o < 8 || o > 23) chk("R2 static untouched", mem[ob + 16'(o)], sent_w(ob, o));
            for (int o = 1; o < 25; o++) chk("R2 new record unwritten", mem[nb + 16'(o)], rec_w(nb, o));
            chk("R3 back-pointer", mem[nb], ns ? 32'(ob) : rec_w(nb, 0));
            chk("R4 ld_ip", ld_ip, rec_w(nb, 8));
            chk("R4 ld_flags", ld_flags, rec_w(nb, 9));
            for (int i = 0; i < 8; i++) chk("R4 ld_gpr", ld_gpr[i*32 +: 32], rec_w(nb, 10 + i));
            for (int i = 0; i < 6; i++) chk("R4 ld_seg", ld_seg[i*32 +: 32], rec_w(nb, 18 + i));
            for (int i = 0; i < 6; i++) chk("R4 ld_stk", ld_stk[i*32 +: 32], rec_w(nb, 1 + i));
            chk("R4 ld_ldt", ld_ldt, rec_w(nb, 24));
            chk("R4 ld_ctrl", ld_ctrl, ctrl_w(nb, tr));
            chk("R5 ld_pdb_valid", 32'(ld_pdb_valid), 32'(pg));
            if (pg) chk("R5 ld_pdb", ld_pdb, rec_w(nb, 7));
            @(negedge clk);
            chk("R4 ld_valid one cycle", 32'(ld_valid), 32'd0);
        end

        // R7: old record runs into absent page 12 (second probe fails)
        fill_old(16'h02F0);
        set_rf(7);
        run_sw(16'h02F0, 16'h0200, 1'b1, 1'b1, 1'b0, lat, gd, gp, sl, sd);
        chk("R7 fault on end page", 32'(gp), 32'd1);
        chk("R9 fault latency probe 2", 32'(lat), 32'd2);
        chk("R7 pf_addr", 32'(pf_addr), 32'h0309);
        chk("R7 no commit", 32'(sl), 32'd0);
        chk("R7 old record untouched", mem[16'h02F8], sent_w(16'h02F0, 8));

        // R7: new record in absent page 14 (third probe fails)
        fill_old(16'h0040);
        run_sw(16'h0040, 16'h0380, 1'b0, 1'b0, 1'b0, lat, gd, gp, sl, sd);
        chk("R7 fault on new start", 32'(gp), 32'd1);
        chk("R9 fault latency probe 3", 32'(lat), 32'd3);
        chk("R7 pf_addr new", 32'(pf_addr), 32'h0380);
        chk("R7 no save before fault", mem[16'h0048], sent_w(16'h0040, 8));
        @(negedge clk);
        chk("R7 ready after fault", 32'(req_ready), 32'd1);

        // R10: a request during a switch is ignored
        fill_old(16'h0280);
        fill_old(16'h0100);
        fill_new(16'h0140, 1'b0);
        set_rf(9);
        run_sw(16'h0100, 16'h0140, 1'b0, 1'b0, 1'b1, lat, gd, gp, sl, sd);
        chk("R10 first switch completes", 32'(lat), 32'd44);
        repeat (4) begin
            @(negedge clk);
            chk("R10 no second switch", 32'(done | mem_valid), 32'd0);
        end
        chk("R10 intruder record untouched", mem[16'h0288], sent_w(16'h0280, 8));

        // R8: memory stalls every other cycle
        fill_old(16'h0180);
        fill_new(16'h01C0, 1'b1);
        set_rf(11);
        stall = 1'b1;
        run_sw(16'h0180, 16'h01C0, 1'b1, 1'b1, 1'b0, lat, gd, gp, sl, sd);
        stall = 1'b0;
        chk("R8 done under stall", 32'(gd), 32'd1);
        chk("R8 latency grows", 32'(lat > 46), 32'd1);
        chk("R8 saved ip", mem[16'h0188], save_exp(8));
        chk("R8 saved last selector", mem[16'h0197], save_exp(23));
        chk("R8 back-pointer", mem[16'h01C0], 32'h0180);
        chk("R8 ld_ip", ld_ip, rec_w(16'h01C0, 8));
        chk("R8 ld_pdb", ld_pdb, rec_w(16'h01C0, 7));
        chk("R8 dbg_trap", 32'(sd), 32'd1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule